// File: doc/BRIEF.md
# Set-Associative Tag Comparator Sweep Engine

This block contains a small four-way tag array, sixteen rows deep, along with its per-way comparators. It also contains a sequencer that tests those comparators without help from software. When started, the sequencer walks every combination of test pattern, row and target way. For each combination it performs three steps. First it fills all four ways of the row with the inverse of the pattern. Then it rewrites only the target way with the pattern itself. Finally it looks the pattern up in that row. The sweep passes only when exactly the target way answers, so the check is on which way hits and not merely on whether a hit occurs.

The lookup compares only the tag bits selected by a caller-supplied mask. The outcome of the sweep is a one-cycle completion pulse and a sticky error flag. The flag keeps the first failure: the row, the way that should have hit, the way that did hit, and whether any way hit at all. The internal write and lookup port activity is driven onto outputs so that the stream of operations can be observed.

Top module: `tag_cmp_sweep`

## Requirements
- R1: While reset is held, and after it is released, `busy`, `done`, `err`, `op_wr` and `op_lk` are all 0. No operation is issued while the block is idle.
- R2: A `start` sampled high while idle begins a sweep on the next clock edge. A `start` sampled while busy has no effect: it changes neither the operation stream nor the completion time.
- R3: The sweep nests its loops as pattern (outermost), then row 0..15, then target way 0..3 (innermost). The patterns are 15'h0000, 15'h7FFF, 15'h5555 and 15'h2AAA, in that order. Each target spends exactly 7 cycles: 4 background writes, 1 target write, 1 lookup and 1 check cycle, with no operation in the check cycle.
- R4: The background writes go to ways 0, 1, 2 and 3 of the current row, in that order. Each carries the pattern XOR 15'h7FFF.
- R5: The target write carries the unmodified pattern (the pattern XOR 0) to the target way. The lookup follows in the next cycle, using the same row and tag. At most one operation is issued per cycle: `op_wr` and `op_lk` are never high together.
- R6: A stored tag matches the lookup tag when they agree on every bit set in `cmp_mask`. With any nonzero mask, every check passes and `err` stays 0.
- R7: When several ways match, the lowest-numbered way is reported. The lookup result is registered and is judged in the cycle after the lookup. With `cmp_mask` = 0, the first failure recorded is row 0, expected way 1, observed way 0, with a hit.
- R8: `done` is high for exactly one cycle, 1792 cycles after the edge that accepted `start`. `busy` falls in that same cycle.
- R9: `err` and the failure fields keep the first failure until the next accepted `start`, which clears them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a sweep (accepted only when idle) |
| cmp_mask | input | 15 | Tag bits that take part in comparison |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse at the end of a sweep |
| err | output | 1 | Sticky: a check failed during the last sweep |
| fail_row | output | 4 | Row of the first failure |
| fail_way | output | 2 | Way that should have hit at the first failure |
| fail_obs_way | output | 2 | Way that did hit at the first failure |
| fail_obs_hit | output | 1 | Whether any way hit at the first failure |
| op_wr | output | 1 | Tag write issued this cycle |
| op_lk | output | 1 | Lookup issued this cycle |
| op_row | output | 4 | Row of the current operation |
| op_way | output | 2 | Way written (valid with op_wr) |
| op_tag | output | 15 | Tag written or looked up |

## Verification
The operation outputs are combinational from the sequencer state. Step k of a sweep is therefore visible in the cycle that follows the k-th edge after the accepting edge. The bench samples each step at the falling edge of that cycle and compares it with a model indexed by k. The lookup verdict lands one edge after the check cycle, so `done` and the failure fields are sampled in the cycle after edge 1792, and the single-cycle width of `done` is confirmed one cycle later. The flag clearing on a new start is observed at step 0 of the following sweep.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_BG   = 3'd1,
    S_TGT  = 3'd2,
    S_LOOK = 3'd3,
    S_CHK  = 3'd4
  } seq_state_e;

  // Fixed test pattern set, indexed by the outer loop counter.
  function automatic logic [15:0] pattern_word(input logic [1:0] sel);
    case (sel)
      2'd0:    pattern_word = 16'h0000;
      2'd1:    pattern_word = 16'h7FFF;
      2'd2:    pattern_word = 16'h5555;
      default: pattern_word = 16'h2AAA;
    endcase
  endfunction

endpackage

// File: rtl/tcs_way_match.sv
module tcs_way_match #(
  parameter int TAG_W = 15
) (
  input  logic [TAG_W-1:0] stored,
  input  logic [TAG_W-1:0] key,
  input  logic [TAG_W-1:0] mask,
  output logic             match
);

  always_comb begin
    match = ~|((stored ^ key) & mask);
  end

endmodule

// File: rtl/tcs_tag_array.sv
module tcs_tag_array #(
  parameter int ROWS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 15,
  localparam int ROW_W = $clog2(ROWS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             lk_en,
  input  logic [ROW_W-1:0] lk_row,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic [TAG_W-1:0] cmp_mask,
  output logic             lk_hit,
  output logic [WAY_W-1:0] lk_way
);

  logic [TAG_W-1:0] tag_q [ROWS][WAYS];
  logic [WAYS-1:0]  match;
  logic [WAY_W-1:0] enc_way;
  logic             any_hit;
  logic             hit_q;
  logic [WAY_W-1:0] way_q;

  // Tag storage: plain memory, written only by the sequencer.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_row][wr_way] <= wr_tag;
    end
  end

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    tcs_way_match #(.TAG_W(TAG_W)) u_match (
      .stored (tag_q[lk_row][g]),
      .key    (lk_tag),
      .mask   (cmp_mask),
      .match  (match[g])
    );
  end

  // Lowest-numbered matching way wins.
  always_comb begin
    enc_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) begin
        enc_way = WAY_W'(w);
      end
    end
    any_hit = |match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      way_q <= '0;
    end else if (lk_en) begin
      hit_q <= any_hit;
      way_q <= enc_way;
    end
  end

  assign lk_hit = hit_q;
  assign lk_way = way_q;

endmodule

// File: rtl/tcs_seq.sv
module tcs_seq
  import tcs_pkg::*;
#(
  parameter int ROWS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 15,
  parameter int NPAT  = 4,
  localparam int ROW_W = $clog2(ROWS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int PAT_W = $clog2(NPAT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             lk_hit,
  input  logic [WAY_W-1:0] lk_way,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [ROW_W-1:0] fail_row,
  output logic [WAY_W-1:0] fail_way,
  output logic [WAY_W-1:0] fail_obs_way,
  output logic             fail_obs_hit,
  output logic             op_wr,
  output logic             op_lk,
  output logic [ROW_W-1:0] op_row,
  output logic [WAY_W-1:0] op_way,
  output logic [TAG_W-1:0] op_tag
);

  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [WAY_W-1:0] WAY_LAST = WAY_W'(WAYS - 1);
  localparam logic [PAT_W-1:0] PAT_LAST = PAT_W'(NPAT - 1);

  seq_state_e       state_q, state_n;
  logic [PAT_W-1:0] pat_q, pat_n;
  logic [ROW_W-1:0] row_q, row_n;
  logic [WAY_W-1:0] tgt_q, tgt_n;
  logic [WAY_W-1:0] bgw_q, bgw_n;
  logic             done_q, done_n;
  logic             err_q, err_n;
  logic [ROW_W-1:0] frow_q, frow_n;
  logic [WAY_W-1:0] fway_q, fway_n;
  logic [WAY_W-1:0] fobs_q, fobs_n;
  logic             fhit_q, fhit_n;

  logic [TAG_W-1:0] cur_pat;
  logic [TAG_W-1:0] flip;
  logic             bad;

  assign cur_pat = TAG_W'(pattern_word(2'(pat_q)));
  // XOR with all ones yields the background, with all zeros the true tag.
  assign flip    = (state_q == S_BG) ? {TAG_W{1'b1}} : {TAG_W{1'b0}};
  assign bad     = !lk_hit || (lk_way != tgt_q);

  always_comb begin
    state_n = state_q;
    pat_n   = pat_q;
    row_n   = row_q;
    tgt_n   = tgt_q;
    bgw_n   = bgw_q;
    done_n  = 1'b0;
    err_n   = err_q;
    frow_n  = frow_q;
    fway_n  = fway_q;
    fobs_n  = fobs_q;
    fhit_n  = fhit_q;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          state_n = S_BG;
          pat_n   = '0;
          row_n   = '0;
          tgt_n   = '0;
          bgw_n   = '0;
          err_n   = 1'b0;
          frow_n  = '0;
          fway_n  = '0;
          fobs_n  = '0;
          fhit_n  = 1'b0;
        end
      end
      S_BG: begin
        if (bgw_q == WAY_LAST) begin
          bgw_n   = '0;
          state_n = S_TGT;
        end else begin
          bgw_n = bgw_q + 1'b1;
        end
      end
      S_TGT:  state_n = S_LOOK;
      S_LOOK: state_n = S_CHK;
      S_CHK: begin
        if (bad && !err_q) begin
          err_n  = 1'b1;
          frow_n = row_q;
          fway_n = tgt_q;
          fobs_n = lk_way;
          fhit_n = lk_hit;
        end
        state_n = S_BG;
        if (tgt_q != WAY_LAST) begin
          tgt_n = tgt_q + 1'b1;
        end else begin
          tgt_n = '0;
          if (row_q != ROW_LAST) begin
            row_n = row_q + 1'b1;
          end else begin
            row_n = '0;
            if (pat_q != PAT_LAST) begin
              pat_n = pat_q + 1'b1;
            end else begin
              pat_n   = '0;
              state_n = S_IDLE;
              done_n  = 1'b1;
            end
          end
        end
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      pat_q   <= '0;
      row_q   <= '0;
      tgt_q   <= '0;
      bgw_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      frow_q  <= '0;
      fway_q  <= '0;
      fobs_q  <= '0;
      fhit_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      pat_q   <= pat_n;
      row_q   <= row_n;
      tgt_q   <= tgt_n;
      bgw_q   <= bgw_n;
      done_q  <= done_n;
      err_q   <= err_n;
      frow_q  <= frow_n;
      fway_q  <= fway_n;
      fobs_q  <= fobs_n;
      fhit_q  <= fhit_n;
    end
  end

  assign busy         = (state_q != S_IDLE);
  assign done         = done_q;
  assign err          = err_q;
  assign fail_row     = frow_q;
  assign fail_way     = fway_q;
  assign fail_obs_way = fobs_q;
  assign fail_obs_hit = fhit_q;
  assign op_wr        = (state_q == S_BG) || (state_q == S_TGT);
  assign op_lk        = (state_q == S_LOOK);
  assign op_row       = row_q;
  assign op_way       = (state_q == S_BG) ? bgw_q : tgt_q;
  assign op_tag       = cur_pat ^ flip;

endmodule

// File: rtl/tag_cmp_sweep.sv
module tag_cmp_sweep #(
  parameter int ROWS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 15,
  localparam int ROW_W = $clog2(ROWS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TAG_W-1:0] cmp_mask,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [ROW_W-1:0] fail_row,
  output logic [WAY_W-1:0] fail_way,
  output logic [WAY_W-1:0] fail_obs_way,
  output logic             fail_obs_hit,
  output logic             op_wr,
  output logic             op_lk,
  output logic [ROW_W-1:0] op_row,
  output logic [WAY_W-1:0] op_way,
  output logic [TAG_W-1:0] op_tag
);

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic             lk_hit;
  logic [WAY_W-1:0] lk_way;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  tcs_seq #(
    .ROWS  (ROWS),
    .WAYS  (WAYS),
    .TAG_W (TAG_W),
    .NPAT  (4)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .start        (start),
    .lk_hit       (lk_hit),
    .lk_way       (lk_way),
    .busy         (busy),
    .done         (done),
    .err          (err),
    .fail_row     (fail_row),
    .fail_way     (fail_way),
    .fail_obs_way (fail_obs_way),
    .fail_obs_hit (fail_obs_hit),
    .op_wr        (op_wr),
    .op_lk        (op_lk),
    .op_row       (op_row),
    .op_way       (op_way),
    .op_tag       (op_tag)
  );

  tcs_tag_array #(
    .ROWS  (ROWS),
    .WAYS  (WAYS),
    .TAG_W (TAG_W)
  ) u_array (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (op_wr),
    .wr_row   (op_row),
    .wr_way   (op_way),
    .wr_tag   (op_tag),
    .lk_en    (op_lk),
    .lk_row   (op_row),
    .lk_tag   (op_tag),
    .cmp_mask (cmp_mask),
    .lk_hit   (lk_hit),
    .lk_way   (lk_way)
  );

endmodule

// File: rtl/tag_cmp_sweep_chk.sv
module tag_cmp_sweep_chk #(
  parameter int ROW_W = 4,
  parameter int WAY_W = 2,
  parameter int TAG_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic [ROW_W-1:0] fail_row,
  input logic [WAY_W-1:0] fail_way,
  input logic [WAY_W-1:0] fail_obs_way,
  input logic             fail_obs_hit,
  input logic             op_wr,
  input logic             op_lk,
  input logic [ROW_W-1:0] op_row,
  input logic [TAG_W-1:0] op_tag
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!op_wr && !op_lk)) else $error("idle op");  // R1

  AST_START_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy) else $error("start lost");  // R2

  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_wr && op_lk)) else $error("two ops");  // R5

  AST_LK_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    op_lk |-> ($past(op_wr) && ($past(op_row) == op_row) && ($past(op_tag) == op_tag)))
    else $error("lookup order");  // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done width");  // R8

  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))) else $error("done vs busy");  // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(start && !busy)) |=> err) else $error("err dropped");  // R9

  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(start && !busy)) |=> ($stable(fail_row) && $stable(fail_way) &&
                                    $stable(fail_obs_way) && $stable(fail_obs_hit)))
    else $error("fail fields moved");  // R9

endmodule

bind tag_cmp_sweep tag_cmp_sweep_chk #(
  .ROW_W (ROW_W),
  .WAY_W (WAY_W),
  .TAG_W (TAG_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .start        (start),
  .busy         (busy),
  .done         (done),
  .err          (err),
  .fail_row     (fail_row),
  .fail_way     (fail_way),
  .fail_obs_way (fail_obs_way),
  .fail_obs_hit (fail_obs_hit),
  .op_wr        (op_wr),
  .op_lk        (op_lk),
  .op_row       (op_row),
  .op_tag       (op_tag)
);

// File: tb/tag_cmp_sweep_bench.sv
`timescale 1ns/1ps
module tag_cmp_sweep_bench;

  localparam int STEPS = 1792;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [14:0] cmp_mask;
  logic        busy, done, err;
  logic [3:0]  fail_row;
  logic [1:0]  fail_way, fail_obs_way;
  logic        fail_obs_hit;
  logic        op_wr, op_lk;
  logic [3:0]  op_row;
  logic [1:0]  op_way;
  logic [14:0] op_tag;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tag_cmp_sweep u_tag_cmp_sweep (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_mask(cmp_mask),
    .busy(busy), .done(done), .err(err), .fail_row(fail_row),
    .fail_way(fail_way), .fail_obs_way(fail_obs_way), .fail_obs_hit(fail_obs_hit),
    .op_wr(op_wr), .op_lk(op_lk), .op_row(op_row), .op_way(op_way), .op_tag(op_tag)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [14:0] pat_of(input int p);
    case (p)
      0:       pat_of = 15'h0000;
      1:       pat_of = 15'h7FFF;
      2:       pat_of = 15'h5555;
      default: pat_of = 15'h2AAA;
    endcase
  endfunction

  // Expected {wr, lk, row, way, tag} at step k; way is zeroed when not a write.
  function automatic logic [22:0] exp_op(input int k);
    int trip = k / 7;
    int ph   = k % 7;
    int tgt  = trip % 4;
    int row  = (trip / 4) % 16;
    int p    = trip / 64;
    logic [14:0] pat = pat_of(p);
    if (ph < 4)       exp_op = {1'b1, 1'b0, 4'(row), 2'(ph),  pat ^ 15'h7FFF};
    else if (ph == 4) exp_op = {1'b1, 1'b0, 4'(row), 2'(tgt), pat};
    else if (ph == 5) exp_op = {1'b0, 1'b1, 4'(row), 2'b00,   pat};
    else              exp_op = {1'b0, 1'b0, 4'(row), 2'b00,   op_tag};
  endfunction

  task automatic run_sweep(input logic [14:0] mask, input bit poke);
    logic [22:0] e, a;
    int cnt;
    string req;
    @(negedge clk);
    cmp_mask = mask;
    start    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(err == 1'b0, "R9 err cleared by start", err, 0);
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    cnt = 0;
    for (int k = 0; k < STEPS; k++) begin
      e = exp_op(k);
      a = {op_wr, op_lk, op_row, (op_wr ? op_way : 2'b00), op_tag};
      if (k % 7 == 6) a[14:0] = op_tag;
      req = (k % 7 < 4) ? "R4 background op" : "R5 target/lookup op";
      if (k % 7 == 6) req = "R3 check cycle op";
      chk(a == e, req, 32'(a), 32'(e));
      chk(done == 1'b0, "R8 no early done", done, 0);
      start = poke && (k < STEPS - 2) && ($urandom_range(0, 15) == 0);
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      cnt++;
    end
    chk(cnt == STEPS, "R8 done latency", cnt, STEPS);
    chk(done == 1'b1, "R8 done at step 1792", done, 1);
    chk(busy == 1'b0, "R8 busy falls with done", busy, 0);
    if (mask == 15'h0000) begin
      chk(err == 1'b1,          "R7 zero mask fails", err, 1);
      chk(fail_row == 4'd0,     "R7 fail row", fail_row, 0);
      chk(fail_way == 2'd1,     "R7 fail expected way", fail_way, 1);
      chk(fail_obs_way == 2'd0, "R7 observed lowest way", fail_obs_way, 0);
      chk(fail_obs_hit == 1'b1, "R7 observed hit", fail_obs_hit, 1);
    end else begin
      chk(err == 1'b0, "R6 nonzero mask passes", err, 0);
    end
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", done, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [14:0] m;
    void'($urandom(32'd2024));
    rst_n    = 1'b0;
    start    = 1'b0;
    cmp_mask = 15'h7FFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({busy, done, err, op_wr, op_lk} == 5'b0, "R1 state in reset",
        {busy, done, err, op_wr, op_lk}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy, done, err, op_wr, op_lk} == 5'b0, "R1 state after reset",
        {busy, done, err, op_wr, op_lk}, 0);

    run_sweep(15'h7FFF, 1'b1);   // R2 start while busy ignored
    run_sweep(15'h0000, 1'b0);   // R7 multiple hits
    repeat (5) @(negedge clk);
    chk(err == 1'b1 && fail_way == 2'd1, "R9 failure held while idle",
        {err, fail_way}, {1'b1, 2'd1});
    chk(op_wr == 1'b0 && op_lk == 1'b0, "R1 idle no ops", {op_wr, op_lk}, 0);
    run_sweep(15'h4000, 1'b0);   // R6 single top bit
    run_sweep(15'h0001, 1'b1);   // R6 single low bit
    for (int i = 0; i < 2; i++) begin
      m = 15'($urandom());
      if (m == 15'h0000) m = 15'h0100;
      run_sweep(m, 1'b1);        // R6 random mask
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule